// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block sits between a CPU-side window onto a serial flash and a byte-wide SPI shifter. Each read or write that lands in the window becomes one SPI transaction for a single chip select. The control word for that chip select decides how the transaction is framed. In the framed modes the block drives chip-enable low, sends an opcode, three or four address bytes, an optional run of dummy bytes and then the data bytes, and afterwards drives chip-enable high again. In user mode it sends only the raw data bytes and leaves chip-enable under software control.

The access address is wrapped into the chip select's segment before it is sent. The segment is given as a power-of-two size. Writes are gated by a write-enable input. An access whose type does not fit the programmed mode produces no serial traffic at all. The shifter is driven one byte at a time: each byte is offered with valid/ready, and the next byte is not offered until the received byte for the previous one has come back. Read data is collected little-endian and returned with a one-cycle response pulse.

Top module: `flash_seq_top`

## Requirements
- R1: `cfg_ctrl[1:0]` selects the mode: 0 read, 1 fast read, 2 write, 3 user. A read is framed in modes 0 and 1. A write is framed in mode 2. Mode 3 sends data bytes only.
- R2: The opcode is `cfg_ctrl[23:16]` in fast-read and write modes. In read mode the opcode sent is always 0x03, whatever that field holds.
- R3: After the opcode, the address goes out most significant byte first: four bytes when `cfg_addr4` is 1, otherwise the low three bytes.
- R4: In fast-read mode only, the address is followed by N dummy bytes, each equal to `cfg_dummy_byte`. N = 8 × {`cfg_ctrl[14]`, `cfg_ctrl[7:6]`}, halved when `cfg_ctrl[28]` is 1. No dummy bytes are sent when N is 0 or in any other mode.
- R5: The address sent is `req_addr` modulo 2^`cfg_seg_log2`. There is no wrap when `cfg_seg_log2` is at least the address width.
- R6: The data phase carries `req_size` bytes (1 to 4). A write sends `req_wdata` lowest byte first. A read sends 0x00 for each byte and returns the received bytes in `rsp_rdata`, the first one in bits [7:0], with the unused upper bytes zero.
- R7: `flash_cs_n` is 0 on every byte of a framed transaction and is 1 in the cycle `rsp_valid` is asserted. Outside transactions it is 1 in modes 0 to 2.
- R8: In user mode `flash_cs_n` equals `cfg_ctrl[2]`, both during the data bytes and while idle.
- R9: A write with `cfg_wr_en` = 0 sends no byte in any mode but still produces a response.
- R10: A read in write mode, or a write in read or fast-read mode, sends no byte. Such a read returns 0.
- R11: `sh_tx_valid` stays high with `sh_tx_data` stable until `sh_tx_ready`. No new byte is offered until `sh_rx_valid` has returned the previous one.
- R12: `req_ready` is 1 only while idle and drops after a request is accepted. `rsp_valid` is a one-cycle pulse per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Window access request |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | ADDR_W | Byte address inside the window |
| req_size | input | SIZE_W | Access size in bytes, 1 to DATA_BYTES |
| req_wdata | input | 8*DATA_BYTES | Write data, little-endian |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8*DATA_BYTES | Read data, little-endian |
| cfg_ctrl | input | 32 | Per-chip-select control word |
| cfg_wr_en | input | 1 | Write enable for this chip select |
| cfg_addr4 | input | 1 | Four-byte addressing |
| cfg_seg_log2 | input | SEG_W | log2 of the segment size in bytes |
| cfg_dummy_byte | input | 8 | Fill value for dummy bytes |
| sh_tx_valid | output | 1 | Byte offered to the shifter |
| sh_tx_data | output | 8 | Byte to shift out |
| sh_tx_ready | input | 1 | Shifter takes the byte |
| sh_rx_valid | input | 1 | Shifter finished a byte |
| sh_rx_data | input | 8 | Byte shifted in |
| flash_cs_n | output | 1 | Chip enable, active low |

## Verification
Random accesses mix all four modes, both access types, sizes 1 to 4, 3- and 4-byte addressing, random dummy fields with and without the halving bit, and segment sizes from 64 KiB up to no wrap. Every emitted byte is compared with a frame built by the bench. This shows whether opcode forcing, address order, dummy count and wrap are right together. Directed cases isolate the read-mode opcode override against a non-zero opcode field, an address exactly one segment size (wraps to 0), the largest dummy run, disabled writes and mode/type mismatches, which must produce no bytes. The random ready and receive delays of the shifter model show whether the sequencer waits for each byte to finish before it starts the next.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_FAST  = 2'd1,
    MODE_WRITE = 2'd2,
    MODE_USER  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DUMMY,
    PH_DATA,
    PH_FIN
  } phase_e;

  localparam int DUMMY_W = 6;
  localparam logic [7:0] OPC_SLOW_READ = 8'h03;

  // control word bit positions
  localparam int CW_CS_STOP  = 2;
  localparam int CW_DUM_LO   = 6;
  localparam int CW_DUM_HI   = 14;
  localparam int CW_OPC_LSB  = 16;
  localparam int CW_HALF_DUM = 28;

  typedef struct packed {
    logic               active;
    logic               framed;
    logic               four;
    logic [7:0]         opcode;
    logic [DUMMY_W-1:0] ndummy;
  } plan_t;

endpackage

// File: rtl/flash_seq_decode.sv
module flash_seq_decode
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int SEG_W      = $clog2(ADDR_W + 1),
  parameter int SIZE_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic [31:0]       ctrl,
  input  logic              is_write,
  input  logic              wr_en,
  input  logic              addr4,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SEG_W-1:0]  seg_log2,
  input  logic [SIZE_W-1:0] size,
  output plan_t             plan,
  output logic [31:0]       addr_out,
  output logic [SIZE_W-1:0] size_out
);

  mode_e              md;
  logic [ADDR_W-1:0]  mask;
  logic [2:0]         raw_dum;
  logic [DUMMY_W-1:0] dum8;
  logic [DUMMY_W-1:0] dum_eff;

  wire unused_ctrl_bits = ^{ctrl[31:29], ctrl[27:24], ctrl[15], ctrl[13:8], ctrl[5:2]};

  always_comb begin
    md = mode_e'(ctrl[1:0]);

    if (32'(seg_log2) >= ADDR_W) mask = '1;
    else                         mask = (ADDR_W'(1) << seg_log2) - ADDR_W'(1);
    addr_out = 32'(addr & mask);

    raw_dum = {ctrl[CW_DUM_HI], ctrl[CW_DUM_LO+1], ctrl[CW_DUM_LO]};
    dum8    = {raw_dum, 3'b000};
    dum_eff = ctrl[CW_HALF_DUM] ? {1'b0, dum8[DUMMY_W-1:1]} : dum8;

    plan.four   = addr4;
    plan.opcode = (md == MODE_READ) ? OPC_SLOW_READ : ctrl[CW_OPC_LSB +: 8];
    plan.ndummy = (md == MODE_FAST) ? dum_eff : '0;
    if (is_write) begin
      plan.active = wr_en && (md == MODE_WRITE || md == MODE_USER);
      plan.framed = (md == MODE_WRITE);
    end else begin
      plan.active = (md != MODE_WRITE);
      plan.framed = (md == MODE_READ || md == MODE_FAST);
    end

    if (size == '0)                       size_out = SIZE_W'(1);
    else if (32'(size) > DATA_BYTES)      size_out = SIZE_W'(DATA_BYTES);
    else                                  size_out = size;
  end

endmodule

// File: rtl/flash_seq_link.sv
module flash_seq_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] byte_in,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       done,
  output logic [7:0] rx_byte
);

  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      waiting  <= 1'b0;
      done     <= 1'b0;
      rx_byte  <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        tx_valid <= 1'b1;
        tx_data  <= byte_in;
      end else if (tx_valid && tx_ready) begin
        tx_valid <= 1'b0;
        waiting  <= 1'b1;
      end else if (waiting && rx_valid) begin
        waiting <= 1'b0;
        done    <= 1'b1;
        rx_byte <= rx_data;
      end
    end
  end

  // R11: byte held until taken
  p_hold_byte_r11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11: no new byte while one is outstanding
  p_single_byte_r11: assert property (@(posedge clk) disable iff (rst)
    go |-> (!tx_valid && !waiting && !done));

endmodule

// File: rtl/flash_seq_pack.sv
module flash_seq_pack #(
  parameter int DATA_BYTES = 4,
  parameter int IDX_W      = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    load,
  input  logic [IDX_W-1:0]        idx,
  input  logic [7:0]              byte_in,
  output logic [8*DATA_BYTES-1:0] data
);

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear)                          data[8*g +: 8] <= '0;
      else if (load && idx == IDX_W'(g))         data[8*g +: 8] <= byte_in;
    end
  end

endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 4,
  parameter int SEG_W      = $clog2(ADDR_W + 1),
  parameter int SIZE_W     = $clog2(DATA_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [SIZE_W-1:0]       req_size,
  input  logic [8*DATA_BYTES-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [8*DATA_BYTES-1:0] rsp_rdata,
  input  logic [31:0]             cfg_ctrl,
  input  logic                    cfg_wr_en,
  input  logic                    cfg_addr4,
  input  logic [SEG_W-1:0]        cfg_seg_log2,
  input  logic [7:0]              cfg_dummy_byte,
  output logic                    sh_tx_valid,
  output logic [7:0]              sh_tx_data,
  input  logic                    sh_tx_ready,
  input  logic                    sh_rx_valid,
  input  logic [7:0]              sh_rx_data,
  output logic                    flash_cs_n
);

  localparam int DATA_W = 8 * DATA_BYTES;
  localparam int IDX_W  = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
  localparam int CNT_W  = DUMMY_W;

  phase_e             phase;
  plan_t              plan_d, plan_q;
  logic [31:0]        addr_d, addr_q;
  logic [SIZE_W-1:0]  size_d, size_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [7:0]         dummy_q;
  logic               write_q;
  logic [CNT_W-1:0]   cnt;
  logic               inflight;
  logic               go;
  logic [7:0]         tx_byte;
  logic               link_done;
  logic [7:0]         link_rx;
  logic               pack_clear, pack_load;
  logic [DATA_W-1:0]  pack_data;
  logic [1:0]         asel;
  logic               framed_busy;
  logic               cs_next;
  logic               last_addr;

  flash_seq_decode #(
    .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .SEG_W(SEG_W), .SIZE_W(SIZE_W)
  ) u_decode (
    .ctrl(cfg_ctrl), .is_write(req_write), .wr_en(cfg_wr_en), .addr4(cfg_addr4),
    .addr(req_addr), .seg_log2(cfg_seg_log2), .size(req_size),
    .plan(plan_d), .addr_out(addr_d), .size_out(size_d)
  );

  flash_seq_link u_link (
    .clk(clk), .rst(rst), .go(go), .byte_in(tx_byte),
    .tx_valid(sh_tx_valid), .tx_data(sh_tx_data), .tx_ready(sh_tx_ready),
    .rx_valid(sh_rx_valid), .rx_data(sh_rx_data),
    .done(link_done), .rx_byte(link_rx)
  );

  flash_seq_pack #(.DATA_BYTES(DATA_BYTES), .IDX_W(IDX_W)) u_pack (
    .clk(clk), .rst(rst), .clear(pack_clear), .load(pack_load),
    .idx(cnt[IDX_W-1:0]), .byte_in(link_rx), .data(pack_data)
  );

  always_comb begin
    framed_busy = plan_q.framed &&
                  (phase inside {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA});
    if (framed_busy)                                cs_next = 1'b0;
    else if (mode_e'(cfg_ctrl[1:0]) == MODE_USER)   cs_next = cfg_ctrl[CW_CS_STOP];
    else                                            cs_next = 1'b1;

    go = !inflight && (phase inside {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA});

    asel      = (plan_q.four ? 2'd3 : 2'd2) - cnt[1:0];
    last_addr = (cnt[1:0] == (plan_q.four ? 2'd3 : 2'd2));

    unique case (phase)
      PH_CMD:   tx_byte = plan_q.opcode;
      PH_ADDR:  tx_byte = addr_q[{asel, 3'b000} +: 8];
      PH_DUMMY: tx_byte = dummy_q;
      PH_DATA:  tx_byte = write_q ? wdata_q[{cnt[IDX_W-1:0], 3'b000} +: 8] : 8'h00;
      default:  tx_byte = 8'h00;
    endcase

    pack_clear = (phase == PH_IDLE) && req_valid;
    pack_load  = (phase == PH_DATA) && link_done && !write_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      plan_q     <= '0;
      addr_q     <= '0;
      size_q     <= '0;
      wdata_q    <= '0;
      dummy_q    <= '0;
      write_q    <= 1'b0;
      cnt        <= '0;
      inflight   <= 1'b0;
      req_ready  <= 1'b1;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      flash_cs_n <= 1'b1;
    end else begin
      rsp_valid  <= 1'b0;
      flash_cs_n <= cs_next;

      if (link_done) inflight <= 1'b0;
      else if (go)   inflight <= 1'b1;

      unique case (phase)
        PH_IDLE: begin
          if (req_valid) begin
            plan_q    <= plan_d;
            addr_q    <= addr_d;
            size_q    <= size_d;
            wdata_q   <= req_wdata;
            dummy_q   <= cfg_dummy_byte;
            write_q   <= req_write;
            cnt       <= '0;
            req_ready <= 1'b0;
            if (!plan_d.active)     phase <= PH_FIN;
            else if (plan_d.framed) phase <= PH_CMD;
            else                    phase <= PH_DATA;
          end
        end
        PH_CMD: begin
          if (link_done) begin
            cnt   <= '0;
            phase <= PH_ADDR;
          end
        end
        PH_ADDR: begin
          if (link_done) begin
            if (last_addr) begin
              cnt   <= '0;
              phase <= (plan_q.ndummy != '0) ? PH_DUMMY : PH_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        PH_DUMMY: begin
          if (link_done) begin
            if (cnt == plan_q.ndummy - CNT_W'(1)) begin
              cnt   <= '0;
              phase <= PH_DATA;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        PH_DATA: begin
          if (link_done) begin
            if (cnt == CNT_W'(size_q) - CNT_W'(1)) phase <= PH_FIN;
            else                                    cnt   <= cnt + CNT_W'(1);
          end
        end
        PH_FIN: begin
          rsp_valid <= 1'b1;
          rsp_rdata <= pack_data;
          req_ready <= 1'b1;
          phase     <= PH_IDLE;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R7: chip enable is low whenever a framed byte is on offer
  p_cs_low_framed_r7: assert property (@(posedge clk) disable iff (rst)
    (sh_tx_valid && plan_q.framed) |-> !flash_cs_n);

  // R12: no request accepted while bytes are moving
  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (rst)
    sh_tx_valid |-> !req_ready);

  // R12: completion is a single-cycle pulse
  p_rsp_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R12: accepted request drops ready
  p_accept_drop_r12: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/flash_seq_top_tb_top.sv
module flash_seq_top_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [2:0]  req_size = 3'd1;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [31:0] cfg_ctrl = '0;
  logic        cfg_wr_en = 1'b0;
  logic        cfg_addr4 = 1'b0;
  logic [5:0]  cfg_seg_log2 = 6'd32;
  logic [7:0]  cfg_dummy_byte = '0;
  logic        sh_tx_valid;
  logic [7:0]  sh_tx_data;
  logic        sh_tx_ready;
  logic        sh_rx_valid;
  logic [7:0]  sh_rx_data;
  logic        flash_cs_n;

  always #4 clk = ~clk;

  flash_seq_top dut_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_ctrl(cfg_ctrl), .cfg_wr_en(cfg_wr_en), .cfg_addr4(cfg_addr4),
    .cfg_seg_log2(cfg_seg_log2), .cfg_dummy_byte(cfg_dummy_byte),
    .sh_tx_valid(sh_tx_valid), .sh_tx_data(sh_tx_data), .sh_tx_ready(sh_tx_ready),
    .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data), .flash_cs_n(flash_cs_n)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  logic [7:0] tx_log [0:127];
  logic       cs_log [0:127];
  logic [7:0] rx_log [0:127];
  logic [7:0] exp_b  [0:127];
  int n_log = 0;
  int exp_n = 0;
  int proto_err = 0;
  int pend = 0;
  logic [7:0] next_rx = '0;

  // shifter model: random acceptance and completion delay
  always @(posedge clk) begin
    if (rst) begin
      sh_tx_ready <= 1'b0;
      sh_rx_valid <= 1'b0;
      sh_rx_data  <= '0;
      pend = 0;
    end else begin
      sh_rx_valid <= 1'b0;
      if (sh_tx_valid && sh_tx_ready) begin
        if (pend != 0) proto_err++;
        next_rx = 8'($urandom);
        if (n_log < 128) begin
          tx_log[n_log] = sh_tx_data;
          cs_log[n_log] = flash_cs_n;
          rx_log[n_log] = next_rx;
        end
        n_log++;
        pend = 1 + int'($urandom % 3);
      end else if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          sh_rx_valid <= 1'b1;
          sh_rx_data  <= next_rx;
        end
      end
      sh_tx_ready <= ($urandom % 4) != 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    if (exp_n < 128) exp_b[exp_n] = b;
    exp_n++;
  endtask

  task automatic run(input bit wr, input logic [31:0] addr, input int size,
                     input logic [31:0] wdata, input logic [31:0] ctrl,
                     input bit a4, input int seg, input bit wren,
                     input logic [7:0] dby, input string tag);
    int tmo;
    int mode;
    bit active, framed;
    logic [31:0] a, got, exp_rd;
    int nab, nd;
    bit cs_end, bytes_ok, cs_ok;
    @(negedge clk);
    cfg_ctrl = ctrl; cfg_addr4 = a4; cfg_seg_log2 = 6'(seg);
    cfg_wr_en = wren; cfg_dummy_byte = dby;
    req_write = wr; req_addr = addr; req_size = 3'(size); req_wdata = wdata;
    n_log = 0; proto_err = 0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R12", "ready after accept", 32'(req_ready), 0);
    tmo = 0;
    while (!rsp_valid && tmo < 5000) begin
      @(negedge clk);
      tmo++;
    end
    chk(rsp_valid == 1'b1, "R12", "response seen", 32'(rsp_valid), 1);
    got = rsp_rdata; cs_end = flash_cs_n;

    mode = int'(ctrl[1:0]);
    if (wr) begin
      active = wren && (mode == 2 || mode == 3);
      framed = (mode == 2);
    end else begin
      active = (mode != 2);
      framed = (mode == 0 || mode == 1);
    end
    exp_n = 0;
    if (active) begin
      if (framed) begin
        push(mode == 0 ? 8'h03 : ctrl[23:16]);
        a = (seg >= 32) ? addr : (addr & ((32'd1 << seg) - 32'd1));
        nab = a4 ? 4 : 3;
        for (int k = 0; k < nab; k++) push(8'(a >> (8 * (nab - 1 - k))));
        if (mode == 1) begin
          nd = int'({ctrl[14], ctrl[7:6]}) * 8;
          if (ctrl[28]) nd = nd / 2;
          for (int k = 0; k < nd; k++) push(dby);
        end
      end
      for (int k = 0; k < size; k++) push(wr ? wdata[8*k +: 8] : 8'h00);
    end

    chk(n_log == exp_n, tag, "byte count", 32'(n_log), 32'(exp_n));
    bytes_ok = 1;
    for (int k = 0; k < exp_n && k < n_log && k < 128; k++)
      if (tx_log[k] !== exp_b[k]) begin
        if (bytes_ok) chk(0, tag, $sformatf("byte %0d", k), 32'(tx_log[k]), 32'(exp_b[k]));
        bytes_ok = 0;
      end
    if (bytes_ok) chk(1, tag, "bytes", 0, 0);

    exp_rd = '0;
    if (!wr && active && n_log >= size)
      for (int k = 0; k < size; k++) exp_rd[8*k +: 8] = rx_log[n_log - size + k];
    if (!wr) chk(got === exp_rd, (active ? "R6" : "R10"), "read data", got, exp_rd);

    if (active && framed) begin
      cs_ok = 1;
      for (int k = 0; k < n_log && k < 128; k++) if (cs_log[k] !== 1'b0) cs_ok = 0;
      chk(cs_ok, "R7", "cs low on frame bytes", 32'(cs_ok), 1);
      chk(cs_end == 1'b1, "R7", "cs released at response", 32'(cs_end), 1);
    end else if (active) begin
      cs_ok = 1;
      for (int k = 0; k < n_log && k < 128; k++) if (cs_log[k] !== ctrl[2]) cs_ok = 0;
      chk(cs_ok, "R8", "user cs follows control bit", 32'(cs_ok), 1);
    end
    chk(proto_err == 0, "R11", "byte overlap", 32'(proto_err), 0);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R12", "response pulse width", 32'(rsp_valid), 0);
  endtask

  function automatic logic [31:0] mk_ctrl(input int mode, input logic [7:0] opc,
                                          input logic [2:0] dum, input bit half,
                                          input bit stop);
    logic [31:0] c;
    c = '0;
    c[1:0]   = 2'(mode);
    c[23:16] = opc;
    c[14]    = dum[2];
    c[7:6]   = dum[1:0];
    c[28]    = half;
    c[2]     = stop;
    return c;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R12", "reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R12", "reset rsp", 32'(rsp_valid), 0);
    chk(sh_tx_valid == 1'b0, "R11", "reset tx_valid", 32'(sh_tx_valid), 0);
    chk(flash_cs_n == 1'b1, "R7", "reset cs", 32'(flash_cs_n), 1);

    // R2: read mode overrides a non-zero opcode field
    run(0, 32'h0012_3456, 4, 0, mk_ctrl(0, 8'hAB, 3'd0, 0, 0), 0, 32, 0, 8'h00, "R2");
    // R2: fast read uses the field
    run(0, 32'h0000_0010, 2, 0, mk_ctrl(1, 8'h0B, 3'd1, 0, 0), 0, 32, 0, 8'hA5, "R2");
    // R3: four-byte address order
    run(0, 32'hDEAD_BEEF, 1, 0, mk_ctrl(0, 8'h00, 3'd0, 0, 0), 1, 32, 0, 8'h00, "R3");
    // R4: largest dummy run, then halved
    run(0, 32'h0000_0100, 1, 0, mk_ctrl(1, 8'h0B, 3'd7, 0, 0), 0, 32, 0, 8'h5C, "R4");
    run(0, 32'h0000_0100, 1, 0, mk_ctrl(1, 8'h0B, 3'd7, 1, 0), 0, 32, 0, 8'h3C, "R4");
    // R4: dummy field ignored in read mode
    run(0, 32'h0000_0200, 1, 0, mk_ctrl(0, 8'h00, 3'd5, 0, 0), 0, 32, 0, 8'hFF, "R4");
    // R5: address equal to segment size wraps to 0
    run(0, 32'h0100_0000, 1, 0, mk_ctrl(0, 8'h00, 3'd0, 0, 0), 1, 24, 0, 8'h00, "R5");
    run(0, 32'h0123_4567, 3, 0, mk_ctrl(0, 8'h00, 3'd0, 0, 0), 1, 20, 0, 8'h00, "R5");
    // R6: write data ordering
    run(1, 32'h0000_0400, 4, 32'h4433_2211, mk_ctrl(2, 8'h02, 3'd0, 0, 0), 0, 32, 1, 8'h00, "R6");
    // R8: user mode raw bytes, both cs values
    run(1, 32'h0, 3, 32'h00C3_B2A1, mk_ctrl(3, 8'h00, 3'd3, 0, 0), 1, 32, 1, 8'h00, "R8");
    run(0, 32'h0, 2, 0, mk_ctrl(3, 8'h00, 3'd3, 0, 1), 1, 32, 0, 8'h00, "R8");
    @(negedge clk);
    chk(flash_cs_n == 1'b1, "R8", "idle user cs", 32'(flash_cs_n), 1);
    // R9: disabled writes in write and user mode
    run(1, 32'h10, 4, 32'hFFFF_FFFF, mk_ctrl(2, 8'h02, 3'd0, 0, 0), 0, 32, 0, 8'h00, "R9");
    run(1, 32'h10, 2, 32'h0000_1234, mk_ctrl(3, 8'h00, 3'd0, 0, 0), 0, 32, 0, 8'h00, "R9");
    // R10: mode/type mismatch
    run(0, 32'h20, 4, 0, mk_ctrl(2, 8'h02, 3'd0, 0, 0), 0, 32, 1, 8'h00, "R10");
    run(1, 32'h20, 4, 32'h1111_2222, mk_ctrl(1, 8'h0B, 3'd1, 0, 0), 0, 32, 1, 8'h00, "R10");
    run(1, 32'h20, 1, 32'h0000_0033, mk_ctrl(0, 8'h00, 3'd0, 0, 0), 0, 32, 1, 8'h00, "R10");

    // R1: random mix of modes and types
    for (int i = 0; i < 70; i++) begin
      run(bit'($urandom % 2), $urandom, 1 + int'($urandom % 4), $urandom,
          mk_ctrl(int'($urandom % 4), 8'($urandom), 3'($urandom), bit'($urandom % 2),
                  bit'($urandom % 2)),
          bit'($urandom % 2), 16 + int'($urandom % 18), bit'(($urandom % 4) != 0),
          8'($urandom), "R1");
    end

    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      chk(0, "R11", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule